// File: doc/BRIEF.md
# Counter-Addressed Pixel Bit Serializer

This block keeps a set of pixel words in small addressable stores and reads every store out one bit per clock, least significant bit first. No store shifts: all of them share a single up-counter whose value is the bit index. The counter steps through every bit position and then stops. Each pixel feeds two serial taps to a downstream Laplacian datapath. The first is the bit selected this cycle, which a consumer can read as the value shifted right by two (a quarter). The second is the same bit two cycles later, which is the full value aligned against the quarter.

Pixels are arranged in groups of four. Each pair of groups owns one 16-bit result shift register. While a run is active, the processed serial result for that pair is shifted into this register. Once the counter stops, the register holds its value so it can be read in parallel. A host writes pixels through a single addressed write port, pulses `start`, and waits for `done_o`.

Top module: `lut_pixel_serializer`

## Requirements
- R1: After reset, `done_o` is 0, every `quarter_o` and `full_o` bit is 0, and every result register reads 0.
- R2: `done_o` rises exactly PIX_W cycles after the clock edge that samples `start`. It stays high until the next `start` or reset, and it is low in the cycle after a `start` edge.
- R3: In the k-th cycle after the `start` edge (k = 0 .. PIX_W-1), `quarter_o[p]` equals bit k of pixel p. In every other cycle it is 0.
- R4: `full_o[p]` equals the value `quarter_o[p]` had two cycles earlier. It is 0 in the first two cycles of a run, and it carries the two highest pixel bits in the two cycles after `done_o` rises.
- R5: A write stores `wr_data` as pixel p = 4*`wr_grp` + `wr_slot`. Pixel p drives bit p of `quarter_o` and of `full_o`.
- R6: A write is ignored while a run is active, that is from the cycle after the `start` edge until `done_o` rises.
- R7: At the end of every active cycle, result bank b shifts right and takes `res_i[b]` into its bit 15. In all other cycles the bank holds its value. The bank reads out on `res_o[16b+15:16b]` and serves groups 2b and 2b+1.
- R8: A `start` during a run restarts from bit 0 and clears both delay stages, so `full_o` is 0 in the first two cycles of the new run.
- R9: The counter stops at its terminal count PIX_W-1 and does not wrap. At the maximum width of 32 this is 31 on a 5-bit counter. After `done_o` rises, `quarter_o` stays 0 until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a serialization run |
| wr_en | input | 1 | Pixel write strobe |
| wr_grp | input | max(1, log2 GROUPS) | Group selected for the write |
| wr_slot | input | 2 | Pixel slot within the group |
| wr_data | input | PIX_W | Pixel value to store |
| quarter_o | output | 4*GROUPS | Undelayed serial tap, one bit per pixel |
| full_o | output | 4*GROUPS | Two-cycle-delayed serial tap, one bit per pixel |
| res_i | input | GROUPS/2 | Serial result input, one per result bank |
| res_o | output | 8*GROUPS | Parallel readout of all 16-bit result banks |
| done_o | output | 1 | Counter has reached its terminal count |

## Verification
The bench builds the block with PIX_W = 32 and GROUPS = 2. This gives the widest case: a 5-bit counter whose terminal count is 31, eight pixels, and a single result bank shared by both groups. With that setting a run is longer than the 16-bit result register, so the final readout depends only on the last sixteen serial inputs. Counter wrap past 31 then shows up as a nonzero quarter tap after `done_o`. The two-stage delay can be observed spilling its last two bits past the end of the count.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int GRP_PIX   = 4;   // pixels held by one storage group
    localparam int RES_W     = 16;  // width of a result shift register
    localparam int MAX_PIX_W = 32;  // widest supported pixel

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    // two-stage alignment line behind each undelayed tap
    typedef struct packed {
        logic stage_a;
        logic stage_b;
    } align_line_t;

    function automatic int addr_bits(input int width);
        return (width > 2) ? $clog2(width) : 1;
    endfunction

    function automatic int sel_bits(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/lps_bit_counter.sv
module lps_bit_counter
    import lps_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = addr_bits(PIX_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] addr,
    output logic             active,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PIX_W - 1);

    run_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            addr  <= '0;
        end else if (start) begin
            state <= ST_RUN;
            addr  <= '0;
        end else if (state == ST_RUN) begin
            if (addr == LAST) begin
                state <= ST_DONE;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    assign active = (state == ST_RUN);
    assign done   = (state == ST_DONE);

endmodule

// File: rtl/lps_pixel_group.sv
module lps_pixel_group
    import lps_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = addr_bits(PIX_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               active,
    input  logic [CNT_W-1:0]   addr,
    input  logic               wr_en,
    input  logic [1:0]         wr_slot,
    input  logic [PIX_W-1:0]   wr_data,
    output logic [GRP_PIX-1:0] quarter,
    output logic [GRP_PIX-1:0] full
);

    for (genvar s = 0; s < GRP_PIX; s++) begin : g_slot
        logic [PIX_W-1:0] store;
        align_line_t      line;
        logic             pick;

        always_ff @(posedge clk) begin
            if (rst) begin
                store <= '0;
            end else if (wr_en && (wr_slot == 2'(s))) begin
                store <= wr_data;
            end
        end

        // bit multiplexer addressed by the shared counter
        assign pick       = store[addr];
        assign quarter[s] = active & pick;

        always_ff @(posedge clk) begin
            if (rst || start) begin
                line <= '0;
            end else begin
                line.stage_a <= quarter[s];
                line.stage_b <= line.stage_a;
            end
        end

        assign full[s] = line.stage_b;
    end

endmodule

// File: rtl/lps_result_bank.sv
module lps_result_bank
    import lps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [RES_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (shift_en) begin
            value <= {ser_in, value[RES_W-1:1]};
        end
    end

endmodule

// File: rtl/lut_pixel_serializer.sv
module lut_pixel_serializer
    import lps_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int GROUPS = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic                              wr_en,
    input  logic [sel_bits(GROUPS)-1:0]       wr_grp,
    input  logic [1:0]                        wr_slot,
    input  logic [PIX_W-1:0]                  wr_data,
    output logic [GROUPS*GRP_PIX-1:0]         quarter_o,
    output logic [GROUPS*GRP_PIX-1:0]         full_o,
    input  logic [GROUPS/2-1:0]               res_i,
    output logic [(GROUPS/2)*RES_W-1:0]       res_o,
    output logic                              done_o
);

    localparam int CNT_W = addr_bits(PIX_W);
    localparam int GW    = sel_bits(GROUPS);
    localparam int NBANK = GROUPS / 2;

    logic [CNT_W-1:0] addr;
    logic             active;

    lps_bit_counter #(
        .PIX_W (PIX_W),
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .addr   (addr),
        .active (active),
        .done   (done_o)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        logic grp_wr;

        assign grp_wr = wr_en && !active && (wr_grp == GW'(g));

        lps_pixel_group #(
            .PIX_W (PIX_W),
            .CNT_W (CNT_W)
        ) u_group (
            .clk     (clk),
            .rst     (rst),
            .start   (start),
            .active  (active),
            .addr    (addr),
            .wr_en   (grp_wr),
            .wr_slot (wr_slot),
            .wr_data (wr_data),
            .quarter (quarter_o[g*GRP_PIX +: GRP_PIX]),
            .full    (full_o[g*GRP_PIX +: GRP_PIX])
        );
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        lps_result_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .shift_en (active),
            .ser_in   (res_i[b]),
            .value    (res_o[b*RES_W +: RES_W])
        );
    end

endmodule

// File: rtl/lps_checker.sv
module lps_checker
    import lps_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int GROUPS = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        start,
    input logic [GROUPS*GRP_PIX-1:0]   quarter_o,
    input logic [GROUPS*GRP_PIX-1:0]   full_o,
    input logic [GROUPS/2-1:0]         res_i,
    input logic [(GROUPS/2)*RES_W-1:0] res_o,
    input logic                        done_o
);

    localparam logic [6:0] K_END = 7'(PIX_W);

    logic [1:0] rst_age;  // edges since reset, saturating
    logic [6:0] run_k;    // cycle index within the current run

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_age <= '0;
        end else if (rst_age != 2'd3) begin
            rst_age <= rst_age + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_k <= '1;
        end else if (start) begin
            run_k <= '0;
        end else if (run_k != '1) begin
            run_k <= run_k + 7'd1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        (rst_age == 2'd0) |-> (!done_o && quarter_o == '0 && full_o == '0 && res_o == '0));

    assert_done_timing_R2: assert property (@(posedge clk) disable iff (rst)
        (rst_age != 2'd0 && $rose(done_o)) |-> (run_k == K_END));

    assert_done_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start) |=> done_o);

    assert_quarter_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (quarter_o == '0));

    assert_full_delay_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_age >= 2'd2 && !$past(start) && !$past(start, 2)) |-> (full_o == $past(quarter_o, 2)));

    assert_res_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start) |=> $stable(res_o));

    assert_res_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (run_k < K_END) |=> (res_o[RES_W-1] == $past(res_i[0])));

endmodule

bind lut_pixel_serializer lps_checker #(
    .PIX_W  (PIX_W),
    .GROUPS (GROUPS)
) u_lps_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .quarter_o (quarter_o),
    .full_o    (full_o),
    .res_i     (res_i),
    .res_o     (res_o),
    .done_o    (done_o)
);

// File: tb/tb_lut_pixel_serializer.sv
module tb_lut_pixel_serializer;

    localparam int PIX_W  = 32;
    localparam int GROUPS = 2;
    localparam int NPIX   = GROUPS * 4;

    localparam logic [31:0] PIX_TAB [4][8] = '{
        '{32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000,
          32'hA5A5_5A5A, 32'h1234_5678, 32'hC000_0003, 32'h7FFF_FFFE},
        '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h3333_CCCC, 32'h5555_AAAA,
          32'h0000_FFFF, 32'hFFFF_0000, 32'h8000_0001, 32'h4000_0002},
        '{32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1357_9BDF, 32'h2468_ACE0,
          32'h0000_0003, 32'hC000_0000, 32'h0001_0000, 32'hFFFE_FFFF},
        '{32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444,
          32'h5555_5555, 32'h6666_6666, 32'h7777_7777, 32'h8888_8888}
    };
    localparam logic [31:0] RES_TAB [4] = '{
        32'h8001_0001, 32'hDEAD_BEEF, 32'h0000_FFFF, 32'h5A5A_C3C3
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            wr_en = 1'b0;
    logic [0:0]      wr_grp = '0;
    logic [1:0]      wr_slot = '0;
    logic [31:0]     wr_data = '0;
    logic [NPIX-1:0] quarter_o;
    logic [NPIX-1:0] full_o;
    logic [0:0]      res_i = '0;
    logic [15:0]     res_o;
    logic            done_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] cur_pix [NPIX];
    logic [15:0] exp_res = '0;

    always #10 clk = ~clk;

    lut_pixel_serializer #(
        .PIX_W  (PIX_W),
        .GROUPS (GROUPS)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .wr_en     (wr_en),
        .wr_grp    (wr_grp),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .quarter_o (quarter_o),
        .full_o    (full_o),
        .res_i     (res_i),
        .res_o     (res_o),
        .done_o    (done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_pix(input int p, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_grp  = 1'(p / 4);
        wr_slot = 2'(p % 4);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one complete run: every cycle checked against the stored-pixel model
    task automatic run_frame(input logic [31:0] rpat, input string tag);
        logic [NPIX-1:0] eq, ef;
        @(negedge clk);
        start = 1'b1;
        res_i = '0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < PIX_W + 3; k++) begin
            res_i = (k < PIX_W) ? rpat[k] : 1'b0;
            for (int p = 0; p < NPIX; p++) begin
                eq[p] = (k < PIX_W) ? cur_pix[p][k] : 1'b0;
                ef[p] = (k >= 2 && k < PIX_W + 2) ? cur_pix[p][k-2] : 1'b0;
            end
            chk(quarter_o == eq, {"R3/R5 quarter ", tag}, 64'(quarter_o), 64'(eq));
            chk(full_o == ef, {"R4 full ", tag}, 64'(full_o), 64'(ef));
            chk(done_o == (k >= PIX_W), {"R2 done ", tag}, 64'(done_o), 64'(k >= PIX_W));
            if (k < PIX_W) exp_res = {rpat[k], exp_res[15:1]};
            @(negedge clk);
        end
        chk(res_o == exp_res, {"R7 result ", tag}, 64'(res_o), 64'(exp_res));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NPIX; p++) cur_pix[p] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'd0);
        chk(quarter_o == '0, "R1 quarter", 64'(quarter_o), 64'd0);
        chk(full_o == '0, "R1 full", 64'(full_o), 64'd0);
        chk(res_o == '0, "R1 result", 64'(res_o), 64'd0);

        // table walk: R5 addressing, R3/R4 streams, R2 timing, R7 capture
        for (int v = 0; v < 4; v++) begin
            for (int p = 0; p < NPIX; p++) begin
                wr_pix(p, PIX_TAB[v][p]);
                cur_pix[p] = PIX_TAB[v][p];
            end
            run_frame(RES_TAB[v], $sformatf("vec%0d", v));
        end

        // R7 and R9: hold after done, counter never wraps
        for (int c = 0; c < 40; c++) begin
            res_i = 1'(c);
            @(negedge clk);
            if (c % 8 == 7) begin
                chk(res_o == exp_res, "R7 hold", 64'(res_o), 64'(exp_res));
                chk(quarter_o == '0, "R9 no wrap", 64'(quarter_o), 64'd0);
                chk(done_o == 1'b1, "R9 stays done", 64'(done_o), 64'd1);
            end
        end

        // R6: a write during an active run is dropped
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        wr_pix(0, 32'hFFFF_FFFF);
        wr_pix(5, 32'h0000_0000);
        repeat (40) @(negedge clk);
        run_frame(32'h0F0F_3C3C, "R6 write ignored");

        // R8: restart in mid-run clears alignment stages
        for (int p = 0; p < NPIX; p++) begin
            wr_pix(p, 32'hFFFF_FFFF ^ 32'(p));
            cur_pix[p] = 32'hFFFF_FFFF ^ 32'(p);
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        chk(full_o != '0, "R8 prerequisite full busy", 64'(full_o), 64'hFF);
        run_frame(32'hAAAA_5555, "R8 restart");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule